// File: doc/BRIEF.md
# Switch Transition Delay Scheduler

This block gives a single switch-like output the timing of a transistor switch, in synthesizable logic. A time unit is one clock cycle in which the `tick_i` enable is high. Each value is one of four states, encoded 2'b00 = logic 0, 2'b01 = logic 1, 2'b10 = unknown (X) and 2'b11 = high-impedance (Z). A strobe on `tgt_vld_i` presents a new destination. The block picks the delay that belongs to that destination and counts it down in time units. It then commits the destination to `out_o`. If a new destination arrives before the countdown ends, the pending change is dropped.

The delays come in three triples: rise, fall and turn-off. Each triple packs a minimum (bits DW-1:0), a typical (bits 2DW-1:DW) and a maximum (bits 3DW-1:2DW) value, and a corner input chooses one member of each. A count input states how many of the three delays are meaningful. It controls how the missing ones are filled in. A separate control lets a falling change from 1 go through Z first, as a pull-down would after the pull-up has released.

Top module: `sw_delay_sched`

## Requirements
- R1: While reset is asserted, and right after it is released, `out_o` is Z (2'b11) and no change is pending.
- R2: With `tick_i` high every cycle, take a strobe sampled at clock edge k with destination 1 and a different current output. `out_o` becomes 1 at edge k+D, where D is the effective rise delay, and does not change before then. D = 0 commits at edge k.
- R3: A destination of 0 follows the same timing as R2, using the effective fall delay.
- R4: A destination of Z follows the same timing as R2, using the effective turn-off delay.
- R5: A destination of X follows the same timing as R2, using the smaller of the effective rise and fall delays.
- R6: `dly_cnt_i` = 1 makes the rise value serve as rise, fall and turn-off. `dly_cnt_i` = 2 uses rise and fall as given, with turn-off set to the smaller of the two. 3 or 0 uses all three values as given.
- R7: `corner_i` = 0 selects the minimum member of every triple, 1 the typical, 2 the maximum, and 3 the typical.
- R8: When `via_z_i` is high, the output is 1 and the destination is 0, `out_o` first goes to Z after the turn-off delay. It then goes to 0 after a further fall delay, counted from the cycle Z appeared.
- R9: A strobe whose destination differs from `out_o` cancels any pending change. The countdown restarts with the delay of the new destination, and the old destination never appears.
- R10: A strobe whose destination equals `out_o` cancels any pending change, starts no countdown, and leaves `out_o` unchanged.
- R11: The countdown advances only in cycles with `tick_i` high. The latency measured in ticks equals the selected delay whatever the tick spacing. A tick in the strobe cycle itself is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One time unit elapses in this cycle |
| tgt_vld_i | input | 1 | Strobe: `tgt_i` holds a new destination |
| tgt_i | input | 2 | Destination value (00=0, 01=1, 10=X, 11=Z) |
| via_z_i | input | 1 | Route 1-to-0 changes through Z |
| dly_cnt_i | input | 2 | Number of configured delays (1, 2, 3; 0 acts as 3) |
| corner_i | input | 2 | Corner select: 0 min, 1 typ, 2 max, 3 typ |
| rise_i | input | 3*DW | Rise delay triple {max, typ, min} |
| fall_i | input | 3*DW | Fall delay triple {max, typ, min} |
| off_i | input | 3*DW | Turn-off delay triple {max, typ, min} |
| out_o | output | 2 | Committed output value |

## Verification
A wrong delay selection or a stale countdown shows up as a commit at the wrong tick. The error is visible on `out_o` within the delay itself, at most 2^DW ticks after the strobe. A pending flag left set after a cancel shows up as a spurious output change several ticks later. A lost second stage of the through-Z fall leaves the output stuck at Z. The bench sweeps every ordered pair of values under every delay-count mode, every corner and two tick spacings. For each case it compares the tick count to commit against an arithmetic expectation and flags any intermediate value.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic [1:0] {
    V0 = 2'b00,
    V1 = 2'b01,
    VX = 2'b10,
    VZ = 2'b11
  } sval_e;

  typedef enum logic [1:0] {
    C_MIN = 2'd0,
    C_TYP = 2'd1,
    C_MAX = 2'd2,
    C_ALT = 2'd3
  } corner_e;
endpackage

// File: rtl/sds_corner_mux.sv
module sds_corner_mux #(
  parameter int DW = 8
) (
  input  logic [3*DW-1:0] trip_i,
  input  logic [1:0]      corner_i,
  output logic [DW-1:0]   val_o
);
  import sds_pkg::*;

  always_comb begin
    case (corner_e'(corner_i))
      C_MIN:   val_o = trip_i[DW-1:0];
      C_MAX:   val_o = trip_i[3*DW-1:2*DW];
      default: val_o = trip_i[2*DW-1:DW];
    endcase
  end
endmodule

// File: rtl/sds_delay_pick.sv
module sds_delay_pick #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] rise_i,
  input  logic [DW-1:0] fall_i,
  input  logic [DW-1:0] off_i,
  input  logic [1:0]    cnt_i,
  input  logic [1:0]    dest_i,
  output logic [DW-1:0] d_dest_o,
  output logic [DW-1:0] d_fall_o,
  output logic [DW-1:0] d_off_o
);
  import sds_pkg::*;

  logic [DW-1:0] r_eff, f_eff, z_eff, rf_min;

  always_comb begin
    r_eff = rise_i;
    f_eff = (cnt_i == 2'd1) ? rise_i : fall_i;
    rf_min = (r_eff < f_eff) ? r_eff : f_eff;
    case (cnt_i)
      2'd1:    z_eff = rise_i;
      2'd2:    z_eff = rf_min;
      default: z_eff = off_i;
    endcase
  end

  always_comb begin
    case (sval_e'(dest_i))
      V1:      d_dest_o = r_eff;
      V0:      d_dest_o = f_eff;
      VZ:      d_dest_o = z_eff;
      default: d_dest_o = rf_min;
    endcase
  end

  assign d_fall_o = f_eff;
  assign d_off_o  = z_eff;
endmodule

// File: rtl/sds_countdown.sv
module sds_countdown #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] val_i,
  input  logic          cancel_i,
  output logic          pend_o,
  output logic          fire_o
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;

  always_comb begin
    fire_o = pend_q && ((cnt_q == '0) || (tick_i && (cnt_q == DW'(1))));
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (load_i) begin
      pend_d = 1'b1;
      cnt_d  = val_i;
    end else if (cancel_i || fire_o) begin
      pend_d = 1'b0;
    end else if (pend_q && tick_i) begin
      cnt_d = cnt_q - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/sw_delay_sched.sv
module sw_delay_sched #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            tgt_vld_i,
  input  logic [1:0]      tgt_i,
  input  logic            via_z_i,
  input  logic [1:0]      dly_cnt_i,
  input  logic [1:0]      corner_i,
  input  logic [3*DW-1:0] rise_i,
  input  logic [3*DW-1:0] fall_i,
  input  logic [3*DW-1:0] off_i,
  output logic [1:0]      out_o
);
  import sds_pkg::*;

  localparam int NSET = 3;

  logic [NSET-1:0][3*DW-1:0] trip;
  logic [NSET-1:0][DW-1:0]   raw;
  logic [DW-1:0]             d_tgt, d_fall, d_off;

  sval_e         out_q, out_d, dest_q, dest_d, tgt_v;
  logic          two_q, two_d, via;
  logic          cd_load, cd_cancel, cd_pend, cd_fire;
  logic [DW-1:0] cd_val;

  assign trip = {off_i, fall_i, rise_i};

  // one corner selector per delay kind
  for (genvar g = 0; g < NSET; g++) begin : g_corner
    sds_corner_mux #(.DW(DW)) u_mux (
      .trip_i  (trip[g]),
      .corner_i(corner_i),
      .val_o   (raw[g])
    );
  end

  sds_delay_pick #(.DW(DW)) u_pick (
    .rise_i  (raw[0]),
    .fall_i  (raw[1]),
    .off_i   (raw[2]),
    .cnt_i   (dly_cnt_i),
    .dest_i  (tgt_i),
    .d_dest_o(d_tgt),
    .d_fall_o(d_fall),
    .d_off_o (d_off)
  );

  sds_countdown #(.DW(DW)) u_cd (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .load_i  (cd_load),
    .val_i   (cd_val),
    .cancel_i(cd_cancel),
    .pend_o  (cd_pend),
    .fire_o  (cd_fire)
  );

  // next-state: strobe handling has priority over an expiring countdown
  always_comb begin
    out_d     = out_q;
    dest_d    = dest_q;
    two_d     = two_q;
    cd_load   = 1'b0;
    cd_cancel = 1'b0;
    cd_val    = '0;
    tgt_v     = sval_e'(tgt_i);
    via       = via_z_i && (out_q == V1) && (tgt_v == V0);
    if (tgt_vld_i) begin
      two_d = 1'b0;
      if (tgt_v == out_q) begin
        cd_cancel = 1'b1;
      end else if (via) begin
        if (d_off == '0) begin
          out_d   = VZ;
          cd_load = 1'b1;
          cd_val  = d_fall;
          dest_d  = V0;
        end else begin
          cd_load = 1'b1;
          cd_val  = d_off;
          dest_d  = VZ;
          two_d   = 1'b1;
        end
      end else if (d_tgt == '0) begin
        out_d     = tgt_v;
        cd_cancel = 1'b1;
      end else begin
        cd_load = 1'b1;
        cd_val  = d_tgt;
        dest_d  = tgt_v;
      end
    end else if (cd_fire) begin
      out_d = dest_q;
      if (two_q) begin
        cd_load = 1'b1;
        cd_val  = d_fall;
        dest_d  = V0;
        two_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= VZ;
      dest_q <= VZ;
      two_q  <= 1'b0;
    end else begin
      out_q  <= out_d;
      dest_q <= dest_d;
      two_q  <= two_d;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/sds_chk.sv
module sds_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tgt_vld_i,
  input logic [1:0] tgt_i,
  input logic [1:0] out_o,
  input logic       pend_i
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RST_Z: assert (out_o == 2'b11 && !pend_i) else $error("reset state"); // R1
    end
  end

  AST_EQ_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_vld_i && tgt_i == out_o) |=> (!pend_i && $stable(out_o))) else $error("equal target"); // R10

  AST_NEW_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_vld_i && tgt_i != out_o) |=> (pend_i || out_o == $past(tgt_i))) else $error("new target"); // R9

  AST_CHANGE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_o != $past(out_o)) |-> ($past(tgt_vld_i) || $past(pend_i))) else $error("spurious change"); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_i && !tgt_vld_i) |=> $stable(out_o)) else $error("idle change"); // R11
endmodule

bind sw_delay_sched sds_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tgt_vld_i(tgt_vld_i),
  .tgt_i    (tgt_i),
  .out_o    (out_o),
  .pend_i   (cd_pend)
);

// File: tb/tb_sw_delay_sched.sv
`timescale 1ns/1ps
module tb_sw_delay_sched;
  localparam int DW = 8;

  logic            clk;
  logic            rst_n;
  logic            tick_i;
  logic            tgt_vld_i;
  logic [1:0]      tgt_i;
  logic            via_z_i;
  logic [1:0]      dly_cnt_i;
  logic [1:0]      corner_i;
  logic [3*DW-1:0] rise_i, fall_i, off_i;
  logic [1:0]      out_o;

  int nchk = 0;
  int nfail = 0;

  sw_delay_sched #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tgt_vld_i(tgt_vld_i),
    .tgt_i(tgt_i), .via_z_i(via_z_i), .dly_cnt_i(dly_cnt_i),
    .corner_i(corner_i), .rise_i(rise_i), .fall_i(fall_i), .off_i(off_i),
    .out_o(out_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pickc(input logic [3*DW-1:0] t, input int c);
    case (c)
      0:       return int'(t[DW-1:0]);
      2:       return int'(t[3*DW-1:2*DW]);
      default: return int'(t[2*DW-1:DW]);
    endcase
  endfunction

  function automatic int exp_d(input int dest, input int cnt, input int c);
    int r, f, z, mn;
    r  = pickc(rise_i, c);
    f  = (cnt == 1) ? r : pickc(fall_i, c);
    mn = (r < f) ? r : f;
    z  = (cnt == 1) ? r : ((cnt == 2) ? mn : pickc(off_i, c));
    case (dest)
      1:       return r;
      0:       return f;
      3:       return z;
      default: return mn;
    endcase
  endfunction

  function automatic string tag_of(input int dest);
    case (dest)
      1:       return "R2 rise";
      0:       return "R3 fall";
      3:       return "R4 turn-off";
      default: return "R5 unknown";
    endcase
  endfunction

  task automatic strobe(input logic [1:0] t);
    tgt_i     = t;
    tgt_vld_i = 1'b1;
    tick_i    = 1'b0;
    @(posedge clk);
    @(negedge clk);
    tgt_vld_i = 1'b0;
  endtask

  task automatic wait_for(input logic [1:0] val, input logic [1:0] start, input int period,
                          output int ticks, output bit stray);
    int step;
    step  = 0;
    ticks = 0;
    stray = 1'b0;
    while (out_o !== val && ticks < 64) begin
      if (out_o !== start) stray = 1'b1;
      tick_i = (step % period == 0);
      step++;
      @(posedge clk);
      if (tick_i) ticks++;
      @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  task automatic go(input int t, input int period, input int cnt, input int c);
    logic [1:0] start;
    int ticks, exp;
    bit stray;
    start = out_o;
    if (int'(start) != t) begin
      exp = exp_d(t, cnt, c);
      strobe(2'(t));
      wait_for(2'(t), start, period, ticks, stray);
      chk(!stray && ticks == exp,
          $sformatf("%s (R6 cnt=%0d, R7 corner=%0d, R11 period=%0d) from %0d",
                    tag_of(t), cnt, c, period, start), ticks, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int t1, t2, bad;
    bit s1, s2;
    rst_n     = 1'b1;
    tick_i    = 1'b0;
    tgt_vld_i = 1'b0;
    tgt_i     = 2'b00;
    via_z_i   = 1'b0;
    dly_cnt_i = 2'd3;
    corner_i  = 2'd1;
    rise_i    = {8'd7, 8'd4, 8'd0};
    fall_i    = {8'd6, 8'd1, 8'd3};
    off_i     = {8'd5, 8'd2, 8'd1};
    #5 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_o == 2'b11, "R1 reset value", out_o, 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_o == 2'b11, "R1 after release", out_o, 3);

    // sweep: tick spacing x count mode x corner x every ordered value pair
    for (int p = 1; p <= 3; p += 2) begin
      for (int cnt = 0; cnt < 4; cnt++) begin
        for (int c = 0; c < 4; c++) begin
          dly_cnt_i = 2'(cnt);
          corner_i  = 2'(c);
          for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
              if (a != b) begin
                go(a, p, cnt, c);
                go(b, p, cnt, c);
              end
            end
          end
        end
      end
    end

    // R8: 1 -> 0 through Z, maximum corner (off 5, fall 6)
    dly_cnt_i = 2'd3;
    corner_i  = 2'd2;
    go(1, 1, 3, 2);
    via_z_i = 1'b1;
    strobe(2'b00);
    wait_for(2'b11, 2'b01, 1, t1, s1);
    chk(!s1 && t1 == 5, "R8 ticks to Z", t1, 5);
    wait_for(2'b00, 2'b11, 1, t2, s2);
    chk(!s2 && t2 == 6, "R8 ticks Z to 0", t2, 6);
    via_z_i = 1'b0;

    // R9: retarget while pending (rise 7, then turn-off 5)
    go(0, 1, 3, 2);
    strobe(2'b01);
    tick_i = 1'b1;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk(out_o == 2'b00, "R9 still old value", out_o, 0);
    strobe(2'b11);
    wait_for(2'b11, 2'b00, 1, t1, s1);
    chk(!s1 && t1 == 5, "R9 restart with new delay", t1, 5);

    // R10: equal target cancels a pending change
    go(0, 1, 3, 2);
    strobe(2'b01);
    tick_i = 1'b1;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
    end
    strobe(2'b00);
    tick_i = 1'b1;
    bad = 0;
    repeat (12) begin
      @(posedge clk);
      @(negedge clk);
      if (out_o !== 2'b00) bad++;
    end
    tick_i = 1'b0;
    chk(bad == 0, "R10 cancelled change stays away", bad, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule